// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave-side protocol engine for a 256-byte serial EEPROM on a two-wire bus. It receives SCL and SDA samples that are already synchronised to the system clock. It drives a single open-drain enable: when `sda_pull_o` is 1, SDA is pulled low. The block detects start and stop conditions, decodes the device address against a fixed type code and three select straps, and keeps an 8-bit word pointer. The contents are held in an internal 256×8 register array.

Incoming write data is collected in an 8-entry latch and nothing reaches the array while the bus transfer is in progress. After a valid stop, the block raises a write-cycle request that shows the start address and the byte count. It then stays deaf to the bus until the programming agent returns a one-cycle done pulse, and at that pulse the latched bytes are copied into the array. A strap input selects page writes or linear writes. Reads return bytes from the word pointer, which advances after each byte, for as long as the master keeps acknowledging.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: An address byte is acknowledged only when bits [7:4] are 1010 and bits [3:1] equal `dev_sel`. Bit 0 = 1 selects a read. Any other address byte gets no acknowledge (SDA stays high in the ninth clock), and the block ignores the bus until the next start.
- R2: In a write, the byte after the address byte sets the word pointer and is acknowledged. Each accepted data byte is acknowledged (SDA low in the ninth clock). After a commit, the array holds those bytes at consecutive pointer values.
- R3: With `page_mode`=1, only pointer bits [2:0] advance after each data byte. Bits [7:3] stay fixed, so the data wraps inside its 8-byte block.
- R4: With `page_mode`=1, a ninth data byte and every later one gets no acknowledge. The whole transfer is then dropped, and no write request is raised.
- R5: With `page_mode`=0, at most seven data bytes are accepted, and the pointer advances across all 8 bits, wrapping from 255 to 0. An eighth data byte gets no acknowledge and drops the whole transfer.
- R6: `wr_req_o` rises only after a stop that ends an accepted write with at least one byte. It then holds with `wr_base_o` and `wr_count_o` until `wr_done_i`, and the array updates at that pulse. While `wr_req_o` is high, the block acknowledges nothing, including its own address.
- R7: A read returns the byte at the word pointer, MSB first, and advances the pointer after each byte, wrapping from 255 to 0. The next byte follows every master acknowledge, with no length limit.
- R8: After a byte that the master does not acknowledge, SDA is released and stays released until the next start.
- R9: A repeated start after a written word address, followed by a read address, reads from that word address.
- R10: `sda_pull_o` is 0 after reset and changes only while SCL is low, after a falling SCL edge.
- R11: A start condition in the middle of a byte restarts the address phase with a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| dev_sel | input | 3 | Device select straps compared to address bits [3:1] |
| page_mode | input | 1 | 1: page writes of up to 8 bytes; 0: linear writes of up to 7 bytes |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| wr_req_o | output | 1 | Write cycle pending; bus input ignored |
| wr_base_o | output | 8 | First word address of the pending write |
| wr_count_o | output | 4 | Number of latched bytes in the pending write |
| wr_done_i | input | 1 | One-cycle pulse ending the write cycle |

## Verification
Some properties are checked on every cycle. SDA may only move while SCL is low. The block must stay silent during a pending write. The request must hold until done, drop only on done, and keep its byte count stable while it holds. Every request must carry a legal count.

The bench scenarios cover the rest, because that behaviour depends on data carried across whole transfers:
- address matching;
- stored values and their placement under both increment modes, including the page wrap and the 255-to-0 wrap;
- discarding of over-long transfers;
- random, current-address and sequential reads;
- release after a master not-acknowledge;
- recovery from a start in the middle of a byte.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int AW = 8,
  parameter int PAGE_N = 8,
  localparam int IDX_W = $clog2(PAGE_N),
  localparam int CW = IDX_W + 1,
  localparam int DEPTH = 1 << AW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    dev_sel,
  input  logic          page_mode,
  output logic          sda_pull_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_base_o,
  output logic [CW-1:0] wr_count_o,
  input  logic          wr_done_i
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD, S_SKIP} st_t;

  st_t           state;
  logic          scl_q, sda_q;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr, base;
  logic [CW-1:0] cnt;
  logic          abort, pg_q, go_rd, mack, busy, pull;
  logic [7:0]    lat [PAGE_N];
  logic [7:0]    mem [DEPTH];

  wire start_c = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c  = scl_i & scl_q & ~sda_q & sda_i;
  wire rise    = scl_i & ~scl_q;
  wire fall    = ~scl_i & scl_q;
  wire active  = (state != S_IDLE) && (state != S_SKIP);
  wire addr_ok = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == dev_sel);

  logic [CW-1:0] lim;
  logic [AW-1:0] ptr_wr_next;
  assign lim = pg_q ? CW'(PAGE_N) : CW'(PAGE_N - 1);
  assign ptr_wr_next = pg_q ? {ptr[AW-1:IDX_W], IDX_W'(ptr[IDX_W-1:0] + 1'b1)}
                            : ptr + 1'b1;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] b,
                                              input int i, input logic pg);
    logic [AW-1:0] lin;
    lin = b + AW'(i);
    return pg ? {b[AW-1:IDX_W], lin[IDX_W-1:0]} : lin;
  endfunction

  assign sda_pull_o = pull;
  assign wr_req_o   = busy;
  assign wr_base_o  = base;
  assign wr_count_o = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      base   <= '0;
      cnt    <= '0;
      abort  <= 1'b0;
      pg_q   <= 1'b0;
      go_rd  <= 1'b0;
      mack   <= 1'b0;
      busy   <= 1'b0;
      pull   <= 1'b0;
      for (int i = 0; i < PAGE_N; i++) lat[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;

      if (busy && wr_done_i) begin
        for (int i = 0; i < PAGE_N; i++)
          if (CW'(i) < cnt) mem[slot_addr(base, i, pg_q)] <= lat[i];
        busy <= 1'b0;
      end

      if (stop_c) begin
        if (!busy && state == S_WD && cnt != '0 && !abort) busy <= 1'b1;
        state <= S_IDLE;
        pull  <= 1'b0;
      end else if (start_c && !busy) begin
        state  <= S_DEV;
        bitcnt <= '0;
        pull   <= 1'b0;
      end else if (rise && active) begin
        if (bitcnt < 4'd8 && state != S_RD) shreg <= {shreg[6:0], sda_i};
        if (bitcnt == 4'd8 && state == S_RD) mack <= ~sda_i;
        bitcnt <= bitcnt + 1'b1;
      end else if (fall && active) begin
        if (bitcnt == 4'd8) begin
          unique case (state)
            S_DEV: begin
              if (addr_ok) begin
                pull  <= 1'b1;
                go_rd <= shreg[0];
              end else begin
                state <= S_SKIP;
              end
            end
            S_WA: begin
              pull  <= 1'b1;
              ptr   <= shreg;
              base  <= shreg;
              cnt   <= '0;
              abort <= 1'b0;
              pg_q  <= page_mode;
            end
            S_WD: begin
              if (!abort && cnt < lim) begin
                pull <= 1'b1;
                lat[cnt[IDX_W-1:0]] <= shreg;
                cnt  <= cnt + 1'b1;
                ptr  <= ptr_wr_next;
              end else begin
                abort <= 1'b1;
              end
            end
            default: pull <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          pull   <= 1'b0;
          unique case (state)
            S_DEV: begin
              if (go_rd) begin
                state <= S_RD;
                shreg <= mem[ptr];
                pull  <= ~mem[ptr][7];
                ptr   <= ptr + 1'b1;
              end else begin
                state <= S_WA;
              end
            end
            S_WA: state <= S_WD;
            S_RD: begin
              if (mack) begin
                shreg <= mem[ptr];
                pull  <= ~mem[ptr][7];
                ptr   <= ptr + 1'b1;
              end else begin
                state <= S_SKIP;
              end
            end
            default: ;
          endcase
        end else if (state == S_RD && bitcnt != 4'd0) begin
          pull <= ~shreg[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
  parameter int PAGE_N = 8,
  parameter int CW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_pull_o,
  input logic          wr_req_o,
  input logic          wr_done_i,
  input logic [CW-1:0] wr_count_o
);

  assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  assert_silent_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> !sda_pull_o);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_done_i) |=> wr_req_o);

  assert_req_drops_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_req_o) |-> $past(wr_done_i));

  assert_count_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req_o) |-> (wr_count_o != '0 && wr_count_o <= CW'(PAGE_N)));

  assert_count_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && $past(wr_req_o)) |-> $stable(wr_count_o));

endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.PAGE_N(PAGE_N), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .wr_req_o(wr_req_o), .wr_done_i(wr_done_i), .wr_count_o(wr_count_o)
);

// File: tb/eeprom_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb_top;
  localparam int Q = 5;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] AW_B = 8'hAA;
  localparam logic [7:0] AR_B = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, page_mode = 1'b0, wr_done = 1'b0, release_ok = 1'b0;
  logic sda_pull, wr_req;
  logic [7:0] wr_base;
  logic [3:0] wr_count;
  wire  sda_bus = sda_m & ~sda_pull;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  string exp_r[$];
  int    exp_v[$];
  int    obs_q[$];

  always #10 clk = ~clk;

  eeprom_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .dev_sel(SEL),
    .page_mode(page_mode), .sda_pull_o(sda_pull), .wr_req_o(wr_req),
    .wr_base_o(wr_base), .wr_count_o(wr_count), .wr_done_i(wr_done)
  );

  task automatic check(string r, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  task automatic expect_v(string r, int v);
    exp_r.push_back(r);
    exp_v.push_back(v);
  endtask

  always @(negedge clk) begin
    int o;
    string r;
    int e;
    if (obs_q.size() > 0) begin
      o = obs_q.pop_front();
      if (exp_v.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard unexpected item actual=%0h expected=none", o);
      end else begin
        r = exp_r.pop_front();
        e = exp_v.pop_front();
        check(r, o, e);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (wr_req && release_ok && !wr_done) begin
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        wait (!wr_req);
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); b = sda_bus; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic send(string r, logic [7:0] v, int exp_ack);
    logic a;
    expect_v(r, exp_ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    obs_q.push_back(a ? 0 : 1);
  endtask

  task automatic recv(string r, logic [7:0] expv, logic mack);
    logic [7:0] v;
    logic b;
    expect_v(r, expv);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
    obs_q.push_back(v);
  endtask

  task automatic set_ptr(string r, logic [7:0] a);
    bus_start();
    send(r, AW_B, 1);
    send(r, a, 1);
  endtask

  task automatic commit();
    release_ok = 1'b1;
    wait (!wr_req);
    @(negedge clk);
    release_ok = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset pull", sda_pull, 0);
    check("R6 reset req", wr_req, 0);

    // R1: wrong select, then wrong type code
    bus_start();
    send("R1 wrong select", 8'hA0, 0);
    bus_stop();
    bus_start();
    send("R1 wrong type", 8'hBA, 0);
    bus_stop();
    check("R1 no request", wr_req, 0);

    // R2 R5 R6: linear write of three bytes
    page_mode = 1'b0;
    set_ptr("R2", 8'h10);
    send("R2 data", 8'h11, 1);
    send("R2 data", 8'h22, 1);
    send("R2 data", 8'h33, 1);
    check("R6 no request before stop", wr_req, 0);
    bus_stop();
    @(negedge clk);
    check("R6 request after stop", wr_req, 1);
    check("R6 base", wr_base, 8'h10);
    check("R6 count", wr_count, 3);
    bus_start();
    send("R6 busy nack", AW_B, 0);
    bus_stop();
    commit();
    check("R6 request cleared", wr_req, 0);

    // R9 R7: random read of written bytes
    set_ptr("R9", 8'h10);
    bus_start();
    send("R9 read addr", AR_B, 1);
    recv("R9 byte0", 8'h11, 1);
    recv("R7 byte1", 8'h22, 1);
    recv("R7 byte2", 8'h33, 0);
    bus_stop();

    // R5: linear wrap 255 -> 0
    set_ptr("R5", 8'hFE);
    send("R5 data", 8'hA1, 1);
    send("R5 data", 8'hA2, 1);
    send("R5 data", 8'hA3, 1);
    send("R5 data", 8'hA4, 1);
    bus_stop();
    commit();
    set_ptr("R7", 8'hFE);
    bus_start();
    send("R7 read addr", AR_B, 1);
    recv("R7 FE", 8'hA1, 1);
    recv("R7 FF", 8'hA2, 1);
    recv("R7 wrap 00", 8'hA3, 0);
    bus_stop();
    bus_start();
    send("R7 current read addr", AR_B, 1);
    recv("R7 current 01", 8'hA4, 0);
    bus_stop();

    // R3: page write wraps low bits
    page_mode = 1'b1;
    set_ptr("R3", 8'h2E);
    send("R3 data", 8'hB0, 1);
    send("R3 data", 8'hB1, 1);
    send("R3 data", 8'hB2, 1);
    send("R3 data", 8'hB3, 1);
    bus_stop();
    @(negedge clk);
    check("R3 count", wr_count, 4);
    commit();
    set_ptr("R3", 8'h28);
    bus_start();
    send("R3 read addr", AR_B, 1);
    recv("R3 at 28", 8'hB2, 1);
    recv("R3 at 29", 8'hB3, 1);
    recv("R3 at 2A", 8'h00, 0);
    bus_stop();
    set_ptr("R3", 8'h2E);
    bus_start();
    send("R3 read addr", AR_B, 1);
    recv("R3 at 2E", 8'hB0, 1);
    recv("R3 at 2F", 8'hB1, 1);
    recv("R3 at 30", 8'h00, 0);
    bus_stop();

    // R4: nine page bytes discard everything
    set_ptr("R4", 8'h40);
    for (int i = 0; i < 9; i++) send("R4 data", 8'hC0 + 8'(i), (i < 8) ? 1 : 0);
    bus_stop();
    repeat (10) @(negedge clk);
    check("R4 no request", wr_req, 0);
    set_ptr("R4", 8'h40);
    bus_start();
    send("R4 read addr", AR_B, 1);
    recv("R4 at 40 untouched", 8'h00, 0);
    bus_stop();

    // R5: eighth linear byte discards everything
    page_mode = 1'b0;
    set_ptr("R5", 8'h50);
    for (int i = 0; i < 8; i++) send("R5 cap", 8'hD0 + 8'(i), (i < 7) ? 1 : 0);
    bus_stop();
    repeat (10) @(negedge clk);
    check("R5 no request", wr_req, 0);

    // R8: release after master not-acknowledge
    set_ptr("R8", 8'h10);
    bus_start();
    send("R8 read addr", AR_B, 1);
    recv("R8 byte", 8'h11, 0);
    expect_v("R8 released", 1);
    get_bit(b);
    obs_q.push_back(b);
    check("R10 pull after nack", sda_pull, 0);
    bus_stop();

    // R11: start in the middle of a byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send("R11 address after restart", AW_B, 1);
    send("R11 word", 8'h11, 1);
    bus_start();
    send("R11 read addr", AR_B, 1);
    recv("R11 data", 8'h22, 0);
    bus_stop();

    repeat (20) @(negedge clk);
    if (exp_v.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_v.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule